// File: doc/BRIEF.md
# Monochrome Colour-Table Pixel Streamer

This block turns packed one-bit-per-pixel data into a stream of colour words, one colour per clock. A controller hands it commands. Each command pairs a 32-bit mode word with a 32-bit data operand. The mode word carries a pixel count, a bit-order flag and a source flag. Each pixel bit picks one of two colour-table entries, and that entry drives the pixel bus for one cycle.

Pixel bits come from one of two sources. The first is a word-wide FIFO that the block pops itself. The second is the command's own data operand, which is reused every 32 pixels. One command can wait behind the running one, so that consecutive runs join without a gap. The colour table, including the idle colour shown between runs, can be rewritten at any time, also in the middle of a run.

Top module: `mono_lut_streamer`

## Requirements
- R1: After reset, `pix_o` is 0, `active_o` is 0, `underrun_o` is 0 and `cmd_ready_o` is 1.
- R2: While no run is in progress, `active_o` is low and `pix_o` shows the idle colour held at table address 2.
- R3: A command with count N in mode bits 15:0 produces exactly N pixels, one per clock. A pixel bit of 0 emits table entry 0 (address 0) and a bit of 1 emits entry 1 (address 1). `active_o` is high exactly while those pixels are on `pix_o`.
- R4: With mode bit 16 clear, pixel k of a 32-pixel word is taken from word bit k, so the least significant bit goes first.
- R5: With mode bit 16 set, the bytes are taken in ascending order, and within each byte the most significant bit goes first. Pixel k uses word bit 8*(k/8) + 7 - (k mod 8).
- R6: With mode bit 17 set, the data operand is the pixel source and is reused every 32 pixels, and `fifo_pop_o` never rises for that run.
- R7: With mode bit 17 clear, one FIFO word is popped at the first pixel of every group of 32. A run of N pixels therefore consumes ceil(N/32) words.
- R8: One command can be held behind the running one, and `cmd_ready_o` is low while both slots are full. The held command's first pixel follows the running command's last pixel on the next clock, with `active_o` staying high.
- R9: A colour-table write takes effect for pixels emitted after the write edge. A pixel emitted on the same edge as the write still uses the old value. Writes to address 3 change nothing.
- R10: When a FIFO run needs a word and `fifo_empty_i` is high, `pix_o` holds its value, `active_o` stays high and `underrun_o` rises. The run resumes once a word is available. `underrun_o` stays set until reset.
- R11: A command with a count of 0 is accepted and discarded, and it produces no pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command slot free |
| cmd_mode_i | input | 32 | Bits 15:0 count, bit 16 top-first, bit 17 immediate source |
| cmd_data_i | input | 32 | Immediate pixel word |
| fifo_data_i | input | 32 | Head word of the pixel FIFO |
| fifo_empty_i | input | 1 | FIFO has no word |
| fifo_pop_o | output | 1 | Head word consumed at this edge |
| lut_we_i | input | 1 | Colour-table write enable |
| lut_addr_i | input | 2 | 0 and 1 are entries, 2 is idle colour |
| lut_data_i | input | COLOR_W | Colour written |
| pix_o | output | COLOR_W | Pixel colour |
| active_o | output | 1 | A run's pixel is on `pix_o` |
| underrun_o | output | 1 | Sticky FIFO starvation flag |

## Verification
The assertions check the queue and flag invariants on every cycle:
- a held command always has a running command in front of it;
- a full queue is followed by an active output;
- zero-count commands never start a run;
- a run never holds a zero remaining count;
- no pop occurs during an immediate run;
- the pixel stays frozen through a stall;
- the underrun flag never clears.

Only the directed scenarios can show the actual colour sequences. These cover both bit orders, both sources, operand reuse past 32 pixels, the gapless join of two queued runs, a mid-run table rewrite, and resumption after a starved FIFO.

// File: rtl/mls_pkg.sv
package mls_pkg;
  localparam int WORD_W  = 32;
  localparam int CNT_W   = 16;
  localparam int BIT_TOP = 16;
  localparam int BIT_IMM = 17;

  typedef struct packed {
    logic              imm;
    logic              top;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] data;
  } run_cmd_t;

  function automatic run_cmd_t decode_cmd(input logic [31:0] mode, input logic [WORD_W-1:0] data);
    run_cmd_t c;
    c.imm  = mode[BIT_IMM];
    c.top  = mode[BIT_TOP];
    c.cnt  = mode[CNT_W-1:0];
    c.data = data;
    return c;
  endfunction
endpackage

// File: rtl/mls_cmd_queue.sv
module mls_cmd_queue
  import mls_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     in_valid_i,
  input  run_cmd_t in_cmd_i,
  output logic     in_ready_o,
  input  logic     emit_i,
  output logic     act_v_o,
  output run_cmd_t act_cmd_o,
  output logic     load_o,
  output run_cmd_t load_cmd_o
);
  logic             act_v_q, buf_v_q;
  run_cmd_t         act_q, buf_q;
  logic [CNT_W-1:0] rem_q;
  logic             done, free_nxt, acc;

  assign done       = act_v_q & emit_i & (rem_q == CNT_W'(1));
  assign free_nxt   = ~act_v_q | done;
  assign in_ready_o = ~(act_v_q & buf_v_q);
  assign acc        = in_valid_i & in_ready_o & (in_cmd_i.cnt != '0);
  assign load_o     = free_nxt & (buf_v_q | acc);
  assign load_cmd_o = buf_v_q ? buf_q : in_cmd_i;
  assign act_v_o    = act_v_q;
  assign act_cmd_o  = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_v_q <= 1'b0;
      act_q   <= '0;
      rem_q   <= '0;
    end else if (load_o) begin
      act_v_q <= 1'b1;
      act_q   <= load_cmd_o;
      rem_q   <= load_cmd_o.cnt;
    end else if (done) begin
      act_v_q <= 1'b0;
    end else if (emit_i) begin
      rem_q   <= rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_v_q <= 1'b0;
      buf_q   <= '0;
    end else if (buf_v_q) begin
      if (load_o) buf_v_q <= 1'b0;
    end else if (acc && !free_nxt) begin
      buf_v_q <= 1'b1;
      buf_q   <= in_cmd_i;
    end
  end

  assert_buf_needs_act_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_v_q |-> act_v_q);
  assert_zero_dropped_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_cmd_i.cnt == '0 && !act_v_q) |=> !act_v_q);
  assert_rem_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_v_q |-> (rem_q != '0));
endmodule

// File: rtl/mls_bit_picker.sv
module mls_bit_picker #(
  parameter int WORD_W = 32,
  parameter int GRP_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_v_i,
  input  logic              act_imm_i,
  input  logic              act_top_i,
  input  logic              load_i,
  input  logic              load_imm_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic [WORD_W-1:0] fifo_data_i,
  input  logic              fifo_empty_i,
  output logic              emit_o,
  output logic              pop_o,
  output logic              bit_o
);
  localparam int IDX_W = $clog2(WORD_W);

  logic [IDX_W-1:0]  k_q, sel;
  logic [WORD_W-1:0] word_q, src;
  logic              first;

  assign first  = (k_q == '0);
  assign emit_o = act_v_i & (act_imm_i | ~first | ~fifo_empty_i);
  assign pop_o  = act_v_i & ~act_imm_i & first & ~fifo_empty_i;
  assign src    = (first && !act_imm_i) ? fifo_data_i : word_q;
  // top-first: byte order kept, bit order inside each byte reversed
  assign sel    = act_top_i ? {k_q[IDX_W-1:GRP_W], ~k_q[GRP_W-1:0]} : k_q;
  assign bit_o  = src[sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q    <= '0;
      word_q <= '0;
    end else if (load_i) begin
      k_q <= '0;
      if (load_imm_i) word_q <= load_data_i;
    end else begin
      if (emit_o) k_q <= k_q + IDX_W'(1);
      if (pop_o)  word_q <= fifo_data_i;
    end
  end
endmodule

// File: rtl/mls_color_table.sv
module mls_color_table #(
  parameter int COLOR_W = 24,
  parameter int N_ENT   = 2,
  parameter int ADDR_W  = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [COLOR_W-1:0]             data_i,
  output logic [N_ENT-1:0][COLOR_W-1:0]  ent_o,
  output logic [COLOR_W-1:0]             idle_o
);
  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               ent_o[i] <= '0;
      else if (we_i && addr_i == ADDR_W'(i))     ent_o[i] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 idle_o <= '0;
    else if (we_i && addr_i == ADDR_W'(N_ENT))   idle_o <= data_i;
  end
endmodule

// File: rtl/mono_lut_streamer.sv
module mono_lut_streamer
  import mls_pkg::*;
#(
  parameter int COLOR_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [31:0]        cmd_mode_i,
  input  logic [31:0]        cmd_data_i,
  input  logic [31:0]        fifo_data_i,
  input  logic               fifo_empty_i,
  output logic               fifo_pop_o,
  input  logic               lut_we_i,
  input  logic [1:0]         lut_addr_i,
  input  logic [COLOR_W-1:0] lut_data_i,
  output logic [COLOR_W-1:0] pix_o,
  output logic               active_o,
  output logic               underrun_o
);
  localparam int N_ENT = 2;

  run_cmd_t                        in_cmd, act_cmd, load_cmd;
  logic                            act_v, load, emit, pix_bit;
  logic [N_ENT-1:0][COLOR_W-1:0]   ent;
  logic [COLOR_W-1:0]              idle_col;
  logic                            unused_mode;

  assign in_cmd      = decode_cmd(cmd_mode_i, cmd_data_i);
  assign unused_mode = ^cmd_mode_i[31:BIT_IMM+1];

  mls_cmd_queue u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (cmd_valid_i),
    .in_cmd_i   (in_cmd),
    .in_ready_o (cmd_ready_o),
    .emit_i     (emit),
    .act_v_o    (act_v),
    .act_cmd_o  (act_cmd),
    .load_o     (load),
    .load_cmd_o (load_cmd)
  );

  mls_bit_picker #(.WORD_W(WORD_W)) u_picker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .act_v_i      (act_v),
    .act_imm_i    (act_cmd.imm),
    .act_top_i    (act_cmd.top),
    .load_i       (load),
    .load_imm_i   (load_cmd.imm),
    .load_data_i  (load_cmd.data),
    .fifo_data_i  (fifo_data_i),
    .fifo_empty_i (fifo_empty_i),
    .emit_o       (emit),
    .pop_o        (fifo_pop_o),
    .bit_o        (pix_bit)
  );

  mls_color_table #(.COLOR_W(COLOR_W), .N_ENT(N_ENT), .ADDR_W(2)) u_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (lut_we_i),
    .addr_i (lut_addr_i),
    .data_i (lut_data_i),
    .ent_o  (ent),
    .idle_o (idle_col)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o      <= '0;
      active_o   <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      active_o <= act_v;
      if (emit)        pix_o <= ent[pix_bit];
      else if (!act_v) pix_o <= idle_col;
      if (act_v && !emit) underrun_o <= 1'b1;
    end
  end

  assert_no_pop_imm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_v && act_cmd.imm) |-> !fifo_pop_o);
  assert_full_means_active_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_ready_o |=> active_o);
  assert_hold_on_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_v && !emit) |=> ($stable(pix_o) && active_o));
  assert_underrun_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o);
endmodule

// File: tb/mono_lut_streamer_bench.sv
module mono_lut_streamer_bench;
  localparam int CW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [31:0]   cmd_mode = '0;
  logic [31:0]   cmd_data = '0;
  logic [31:0]   fifo_data;
  logic          fifo_empty;
  logic          fifo_pop;
  logic          lut_we = 1'b0;
  logic [1:0]    lut_addr = '0;
  logic [CW-1:0] lut_data = '0;
  logic [CW-1:0] pix;
  logic          active;
  logic          underrun;

  int total = 0;
  int bad = 0;

  logic [31:0]   fifo_mem [0:15];
  int            fifo_n = 0;
  int            rd_ptr = 0;
  logic          pop_pend = 1'b0;

  logic [CW-1:0] cap [0:255];
  int            cap_n = 0;
  int            rises = 0;
  logic          prev_act = 1'b0;

  logic [CW-1:0] c0 = '0, c1 = '0, cidle = '0;

  always #4 clk = ~clk;

  assign fifo_empty = (rd_ptr == fifo_n);
  assign fifo_data  = fifo_mem[rd_ptr[3:0]];

  mono_lut_streamer #(.COLOR_W(CW)) u_mono_lut_streamer (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_mode_i(cmd_mode), .cmd_data_i(cmd_data),
    .fifo_data_i(fifo_data), .fifo_empty_i(fifo_empty), .fifo_pop_o(fifo_pop),
    .lut_we_i(lut_we), .lut_addr_i(lut_addr), .lut_data_i(lut_data),
    .pix_o(pix), .active_o(active), .underrun_o(underrun)
  );

  always @(negedge clk) begin
    if (pop_pend) rd_ptr = rd_ptr + 1;
    pop_pend = fifo_pop;
    if (active && !prev_act) rises = rises + 1;
    prev_act = active;
    if (active && cap_n < 256) begin
      cap[cap_n] = pix;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [31:0] w, input int k, input logic top);
    if (top) return w[(k / 8) * 8 + 7 - (k % 8)];
    return w[k];
  endfunction

  function automatic logic [31:0] mk_mode(input logic imm, input logic top, input int cnt);
    return {14'd0, imm, top, cnt[15:0]};
  endfunction

  task automatic lut_write(input logic [1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    lut_we = 1'b1; lut_addr = a; lut_data = d;
    @(negedge clk);
    lut_we = 1'b0;
    if (a == 2'd0) c0 = d;
    if (a == 2'd1) c1 = d;
    if (a == 2'd2) cidle = d;
  endtask

  task automatic issue(input logic [31:0] mode, input logic [31:0] data);
    cmd_valid = 1'b1; cmd_mode = mode; cmd_data = data;
    #1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic clr_cap();
    cap_n = 0;
    rises = 0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (active) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_px(input string tag, input int off, input int cnt, input logic top,
                          input logic imm, input logic [31:0] imm_w, input int fw0);
    for (int p = 0; p < cnt; p++) begin
      logic [31:0] w;
      w = imm ? imm_w : fifo_mem[fw0 + p / 32];
      chk(tag, 32'(cap[off + p]), 32'(exp_bit(w, p % 32, top) ? c1 : c0));
    end
  endtask

  task automatic t_reset();
    chk("R1 pix", 32'(pix), 0);
    chk("R1 active", 32'(active), 0);
    chk("R1 underrun", 32'(underrun), 0);
    chk("R1 ready", 32'(cmd_ready), 1);
  endtask

  task automatic t_idle();
    lut_write(2'd0, 24'h102030);
    lut_write(2'd1, 24'hF0E0D0);
    lut_write(2'd2, 24'h5A5A5A);
    repeat (2) @(negedge clk);
    chk("R2 idle colour", 32'(pix), 32'(cidle));
    chk("R2 inactive", 32'(active), 0);
    lut_write(2'd3, 24'h000001);
    repeat (2) @(negedge clk);
    chk("R9 addr3 ignored", 32'(pix), 32'(cidle));
  endtask

  task automatic t_imm_bottom();
    fifo_mem[0] = 32'hC3A5_0F81; fifo_n = 1;
    clr_cap();
    issue(mk_mode(1'b1, 1'b0, 40), 32'h8001_F00D);
    wait_idle();
    chk("R3 count", cap_n, 40);
    check_px("R4 bottom-first", 0, 40, 1'b0, 1'b1, 32'h8001_F00D, 0);
    chk("R6 no pop imm", rd_ptr, 0);
    repeat (2) @(negedge clk);
    chk("R2 idle after run", 32'(pix), 32'(cidle));
  endtask

  task automatic t_imm_top();
    clr_cap();
    issue(mk_mode(1'b1, 1'b1, 36), 32'h0180_7E13);
    wait_idle();
    chk("R3 count top", cap_n, 36);
    check_px("R5 top-first", 0, 36, 1'b1, 1'b1, 32'h0180_7E13, 0);
    chk("R6 no pop imm top", rd_ptr, 0);
  endtask

  task automatic t_fifo();
    fifo_mem[1] = 32'h1234_5678; fifo_mem[2] = 32'hFFFF_0000; fifo_n = 3;
    clr_cap();
    issue(mk_mode(1'b0, 1'b0, 80), 32'hDEAD_BEEF);
    wait_idle();
    chk("R7 count", cap_n, 80);
    check_px("R7 fifo bottom", 0, 80, 1'b0, 1'b0, 0, 0);
    chk("R7 words popped", rd_ptr, 3);
    fifo_mem[3] = 32'h8F01_2480; fifo_n = 4;
    clr_cap();
    issue(mk_mode(1'b0, 1'b1, 32), 32'h0);
    wait_idle();
    check_px("R5 fifo top", 0, 32, 1'b1, 1'b0, 0, 3);
    chk("R7 one word", rd_ptr, 4);
  endtask

  task automatic t_back_to_back();
    clr_cap();
    issue(mk_mode(1'b1, 1'b0, 20), 32'h000A_5A53);
    issue(mk_mode(1'b1, 1'b1, 12), 32'h0000_0C81);
    #1;
    chk("R8 ready low when full", 32'(cmd_ready), 0);
    wait_idle();
    chk("R8 total", cap_n, 32);
    chk("R8 no gap", rises, 1);
    check_px("R8 first run", 0, 20, 1'b0, 1'b1, 32'h000A_5A53, 0);
    check_px("R8 second run", 20, 12, 1'b1, 1'b1, 32'h0000_0C81, 0);
  endtask

  task automatic t_lut_midline();
    logic [CW-1:0] old_c1;
    int ny, nz, order_bad;
    old_c1 = c1;
    clr_cap();
    issue(mk_mode(1'b1, 1'b0, 100), 32'hFFFF_FFFF);
    repeat (30) @(negedge clk);
    lut_write(2'd1, 24'h00C0FF);
    wait_idle();
    ny = 0; nz = 0; order_bad = 0;
    for (int p = 0; p < cap_n; p++) begin
      if (cap[p] == old_c1) begin
        ny++;
        if (nz != 0) order_bad++;
      end else if (cap[p] == c1) nz++;
      else order_bad++;
    end
    chk("R9 count", cap_n, 100);
    chk("R9 old before new", order_bad, 0);
    chk("R9 old seen", 32'(ny > 0), 1);
    chk("R9 new seen", 32'(nz > 0), 1);
  endtask

  task automatic t_zero_count();
    clr_cap();
    issue(mk_mode(1'b1, 1'b0, 0), 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    chk("R11 no run", 32'(active), 0);
    chk("R11 ready", 32'(cmd_ready), 1);
    issue(mk_mode(1'b1, 1'b0, 5), 32'h0000_0015);
    wait_idle();
    chk("R11 only later run", cap_n, 5);
    check_px("R11 later run", 0, 5, 1'b0, 1'b1, 32'h0000_0015, 0);
  endtask

  task automatic t_underrun();
    int off;
    chk("R10 clear before", 32'(underrun), 0);
    clr_cap();
    issue(mk_mode(1'b0, 1'b0, 8), 32'h0);
    repeat (4) @(negedge clk);
    chk("R10 active in stall", 32'(active), 1);
    chk("R10 flag", 32'(underrun), 1);
    chk("R10 hold colour", 32'(pix), 32'(cidle));
    fifo_mem[4] = 32'h0000_00B6; fifo_n = 5;
    wait_idle();
    off = cap_n - 8;
    check_px("R10 resumed", off, 8, 1'b0, 1'b0, 0, 4);
    chk("R10 sticky", 32'(underrun), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_imm_bottom();
    t_imm_top();
    t_fifo();
    t_back_to_back();
    t_lut_midline();
    t_zero_count();
    t_underrun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule